// File: doc/BRIEF.md
# ATM Cell Path-Integrity Marker

This block sits on the receive side of an ATM cell processor. It takes the byte-wide cell stream that has already been delineated and filtered, and hands it on to the receive FIFO. Each cell is 53 octets long. A start-of-cell strobe and a valid strobe travel with the data. Octets 1 to 4 and 6 to 53 pass through untouched. The fifth octet is the header error check (HEC) byte, and the block can overwrite it with a known test byte. A checker further down the cell path then compares that byte against the expected sequence, which shows whether the connection through the ATM layer is intact.

Two configuration inputs control the marker:

- The enable input chooses between inserting the test byte and keeping the received HEC.
- The select input chooses the test byte. It is either a constant 55h on every cell, or a value that alternates between 55h and AAh from one cell to the next.

Both inputs are sampled on the start-of-cell beat and then held for the rest of that cell. The output stream is registered and lags the input by one clock.

Top module: `cell_hec_marker`

## Requirements
- R1: Every valid octet whose zero-based position in the cell is not 4 appears at the output unchanged.
- R2: The octet at position 4 (the octet after the four header octets) is the only one that can be replaced, and it is replaced only when insertion is enabled for that cell.
- R3: With `ins_en_i` = 0 at the start-of-cell beat, octet 4 is forwarded with its received value, whatever the value of `fixed_sel_i`.
- R4: With `ins_en_i` = 1 and `fixed_sel_i` = 1, octet 4 becomes 8'h55 on every cell.
- R5: With `ins_en_i` = 1 and `fixed_sel_i` = 0, octet 4 takes the current phase value: 8'h55 in phase 0 and 8'hAA in phase 1. The phase is 0 after reset.
- R6: The phase inverts on the valid beat carrying octet 52 (the final octet) of a cell that has insertion enabled, in either pattern mode. It does not change for cells with insertion disabled, or for cells that are cut short by a new start-of-cell before octet 52.
- R7: The octet position advances only on beats with `in_valid_i` = 1, so idle cycles inside a cell do not move the octet that gets replaced.
- R8: A valid beat with `in_soc_i` = 1 is octet 0 of a new cell, even when the previous cell is incomplete. Valid octets that arrive after reset and before the first start-of-cell are never altered.
- R9: `out_valid_o` and `out_soc_o` equal `in_valid_i` and `in_valid_i & in_soc_i` from one clock earlier, and `out_data_o` carries that earlier beat's octet.
- R10: `ins_en_i` and `fixed_sel_i` are sampled only on the start-of-cell beat. Changing them in the middle of a cell has no effect on that cell, including on its phase advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | 8 | Incoming cell octet |
| in_valid_i | input | 1 | Incoming octet is valid |
| in_soc_i | input | 1 | Incoming octet is the first of a cell (qualified by valid) |
| ins_en_i | input | 1 | Replace octet 4 with the test byte |
| fixed_sel_i | input | 1 | 1: constant 55h, 0: alternate 55h/AAh per cell |
| out_data_o | output | 8 | Outgoing octet, one clock later |
| out_valid_o | output | 1 | Outgoing octet is valid |
| out_soc_o | output | 1 | Outgoing octet is the first of a cell |

## Verification
Two events can land on the same beat. The configuration capture at start-of-cell can coincide with the moment software changes the enable or select inputs. The phase advance on a cell's final octet can coincide with a mid-cell flip of those same inputs. The bench provokes both cases: it presents new settings on the start-of-cell beat itself, and it inverts them from octet 2 onward, so the change is still present on the final octet. The scoreboard models the cell with the captured settings and its own phase bit. A wrong capture therefore shows up in that cell's octet 4, and a wrong phase advance shows up in the octet 4 of the next alternating cell.

// File: rtl/cell_mark_pkg.sv
package cell_mark_pkg;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_CELL_LEN = 53;
  localparam int unsigned DEF_MARK_IDX = 4;
  localparam logic [7:0]  DEF_PAT_A    = 8'h55;
  localparam logic [7:0]  DEF_PAT_B    = 8'hAA;

  typedef struct packed {
    logic en;
    logic fixed;
  } mark_cfg_t;
endpackage

// File: rtl/cell_octet_pos.sv
module cell_octet_pos #(
  parameter int unsigned CELL_LEN = cell_mark_pkg::DEF_CELL_LEN,
  localparam int unsigned POS_W   = $clog2(CELL_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             soc_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] IDLE_POS = POS_W'(CELL_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_LEN - 1);

  logic [POS_W-1:0] cnt_q;

  // idle value CELL_LEN marks "outside any cell"
  assign pos_o  = soc_i ? '0 : cnt_q;
  assign last_o = (pos_o == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= IDLE_POS;
    else if (valid_i)
      cnt_q <= (pos_o == IDLE_POS) ? IDLE_POS : pos_o + 1'b1;
  end

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && soc_i) |=> (cnt_q == POS_W'(1)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
endmodule

// File: rtl/cell_mark_cfg.sv
module cell_mark_cfg
  import cell_mark_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      soc_i,
  input  logic      last_i,
  input  logic      en_i,
  input  logic      fixed_i,
  output mark_cfg_t cfg_o,
  output logic      phase_o
);
  mark_cfg_t cfg_q;
  logic      phase_q;
  logic      capture;

  assign capture = valid_i && soc_i;
  assign cfg_o   = capture ? '{en: en_i, fixed: fixed_i} : cfg_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{en: 1'b0, fixed: 1'b1};
      phase_q <= 1'b0;
    end else begin
      if (capture) cfg_q <= '{en: en_i, fixed: fixed_i};
      if (valid_i && last_i && cfg_o.en) phase_q <= ~phase_q;
    end
  end

  a_r6_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last_i && cfg_o.en) |=> $stable(phase_q));
  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && soc_i) |=> $stable(cfg_q));
endmodule

// File: rtl/cell_hec_marker.sv
module cell_hec_marker
  import cell_mark_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned CELL_LEN = DEF_CELL_LEN,
  parameter int unsigned MARK_IDX = DEF_MARK_IDX,
  parameter logic [DATA_W-1:0] PAT_A = DATA_W'(DEF_PAT_A),
  parameter logic [DATA_W-1:0] PAT_B = DATA_W'(DEF_PAT_B)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_soc_i,
  input  logic              ins_en_i,
  input  logic              fixed_sel_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_soc_o
);
  localparam int unsigned POS_W = $clog2(CELL_LEN + 1);
  localparam logic [POS_W-1:0] MARK_POS = POS_W'(MARK_IDX);

  logic [POS_W-1:0] pos;
  logic             last;
  mark_cfg_t        cfg;
  logic             phase;
  logic [DATA_W-1:0] pattern;
  logic              hit;

  cell_octet_pos #(.CELL_LEN(CELL_LEN)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .soc_i  (in_soc_i),
    .pos_o  (pos),
    .last_o (last)
  );

  cell_mark_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .soc_i  (in_soc_i),
    .last_i (last),
    .en_i   (ins_en_i),
    .fixed_i(fixed_sel_i),
    .cfg_o  (cfg),
    .phase_o(phase)
  );

  assign pattern = (cfg.fixed || !phase) ? PAT_A : PAT_B;
  assign hit     = in_valid_i && (pos == MARK_POS) && cfg.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
      out_soc_o   <= 1'b0;
    end else begin
      out_data_o  <= hit ? pattern : in_data_i;
      out_valid_o <= in_valid_i;
      out_soc_o   <= in_valid_i && in_soc_i;
    end
  end

  a_r9_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && !out_soc_o));
  a_r1_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && pos != MARK_POS) |=> (out_data_o == $past(in_data_i)));
  a_r3_keep_hec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && pos == MARK_POS && !cfg.en) |=> (out_data_o == $past(in_data_i)));
  a_r4_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && pos == MARK_POS && cfg.en && cfg.fixed) |=> (out_data_o == PAT_A));
endmodule

// File: tb/tb_cell_hec_marker.sv
module tb_cell_hec_marker;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0;
  logic       in_soc_i = 1'b0;
  logic       ins_en_i = 1'b0;
  logic       fixed_sel_i = 1'b0;
  logic [7:0] out_data_o;
  logic       out_valid_o;
  logic       out_soc_o;

  cell_hec_marker dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_soc_i(in_soc_i),
    .ins_en_i(ins_en_i), .fixed_sel_i(fixed_sel_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_soc_o(out_soc_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    alt = 1'b0;
  bit    done = 1'b0;
  logic [7:0] q_d[$];
  logic       q_soc[$];
  int         q_cyc[$];
  string      q_tag[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (out_valid_o) begin
        if (q_d.size() == 0) begin
          chk(1'b0, "R9", 1, 0);
        end else begin
          logic [7:0] ed;
          logic       es;
          int         ec;
          string      et;
          ed = q_d.pop_front(); es = q_soc.pop_front();
          ec = q_cyc.pop_front(); et = q_tag.pop_front();
          chk(out_data_o == ed, et, out_data_o, ed);
          chk(out_soc_o == es, "R9", out_soc_o, es);
          chk(cyc == ec + 1, "R9", cyc, ec + 1);
        end
      end else begin
        chk(!out_soc_o, "R9", out_soc_o, 0);
      end
    end
  end

  task automatic idle();
    in_valid_i = 1'b0; in_soc_i = 1'b0; in_data_i = 8'($urandom);
    @(posedge clk_i); #1;
  endtask

  task automatic beat(input logic [7:0] d, input logic soc, input logic [7:0] e, input string t);
    in_data_i = d; in_valid_i = 1'b1; in_soc_i = soc;
    q_d.push_back(e); q_soc.push_back(soc); q_cyc.push_back(cyc); q_tag.push_back(t);
    @(posedge clk_i); #1;
    in_valid_i = 1'b0; in_soc_i = 1'b0;
  endtask

  // n octets; gaps inserts idle cycles; flip inverts cfg from octet 2 on
  task automatic send_cell(input bit en, input bit sel, input int n, input bit gaps,
                           input bit flip, input string tag);
    ins_en_i = en; fixed_sel_i = sel;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [7:0] e;
      string      t;
      d = 8'($urandom);
      if (i == 4) begin
        e = !en ? d : ((sel || !alt) ? 8'h55 : 8'hAA);
        t = (tag != "") ? tag : (!en ? "R3" : (sel ? "R4" : "R5"));
      end else begin
        e = d;
        t = "R1";
      end
      beat(d, i == 0, e, t);
      if (flip && i == 1) begin ins_en_i = !en; fixed_sel_i = !sel; end
      if (gaps && (i % 3 == 1)) begin idle(); idle(); end
    end
    if (n == 53 && en) alt = !alt;
  endtask

  always @(posedge clk_i) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R9", out_valid_o, 0);
    chk(out_soc_o == 1'b0, "R9", out_soc_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R8: octets before any start-of-cell are untouched
    ins_en_i = 1'b1; fixed_sel_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      beat(d, 1'b0, d, "R8");
    end
    idle();
    // R5: alternation from reset, back-to-back cells
    send_cell(1, 0, 53, 0, 0, "R5");
    send_cell(1, 0, 53, 0, 0, "R5");
    send_cell(1, 0, 53, 0, 0, "R5");
    // R3 with select ignored; R6 no phase advance after disabled cell
    send_cell(0, 0, 53, 0, 0, "R3");
    send_cell(0, 1, 53, 0, 0, "R3");
    send_cell(1, 0, 53, 0, 0, "R6");
    // R4 fixed; R6 phase advances in fixed mode too
    send_cell(1, 1, 53, 0, 0, "R4");
    send_cell(1, 1, 53, 0, 0, "R4");
    send_cell(1, 0, 53, 0, 0, "R6");
    // R7 gaps inside a cell
    send_cell(1, 0, 53, 1, 0, "R7");
    send_cell(0, 0, 53, 1, 0, "R7");
    // R8 truncated cell then fresh cell; R6 no advance on truncation
    send_cell(1, 0, 20, 0, 0, "R8");
    send_cell(1, 0, 3, 0, 0, "R8");
    send_cell(1, 0, 53, 0, 0, "R6");
    idle();
    // R10 mid-cell changes ignored, including at final octet
    send_cell(1, 0, 53, 0, 1, "R10");
    send_cell(0, 1, 53, 0, 1, "R10");
    send_cell(1, 0, 53, 0, 1, "R10");
    send_cell(1, 1, 53, 1, 1, "R10");
    send_cell(1, 0, 53, 0, 0, "R2");
    send_cell(1, 0, 53, 0, 0, "R2");
    repeat (4) idle();
    chk(q_d.size() == 0, "R9", q_d.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule